// File: doc/BRIEF.md
# Precision Time Dialog Responder Reply Selector

This block serves the responder end of a time measurement exchange on a downstream link port. When a request arrives it latches the running master-time value as the receive stamp (T2). When the reply leaves it latches the master time again as the transmit stamp (T3). It tracks validity for the dialog in progress and for the dialog that finished before it. For every request it decides whether the reply carries data. A data reply carries the master time, which is the current T2, and the propagation delay, which is the previous dialog's T3 minus its T2.

Duplicate requests and replayed replies are reported by the link layer beside the strobes. An enhanced-mode input tightens the rules for both. A duplicate request then forces a plain reply. A replayed reply discards the previous dialog's stamps. The reply decision is presented one cycle after the request strobe and is held until the packet builder acknowledges it.

Top module: `tm_reply_select`

## Requirements
- R1: A request strobe (`req_rx`) latches `master_time` as T2. The T2 in force when a reply is built is the value from the most recent request, including a duplicate one. `rpl_master` carries that T2 for both reply kinds.
- R2: `rpl_is_data` is 1 (data reply) only when the T2 just latched is valid and both T2 and T3 of the previous dialog are valid. Otherwise it is 0 (plain reply).
- R3: `rpl_delay` equals the previous dialog's T3 minus its T2, taken modulo 2^TS_W.
- R4: A response strobe (`rsp_tx`) without replay closes the dialog. The current T2 and its validity become the previous T2. `master_time` at that strobe becomes the previous T3 and is marked valid. The current T2 is then marked invalid.
- R5: A duplicate request (`req_dup` with `req_rx`) leaves T2 invalid when `enh_en` is 1, or when the parameter DUP_INVALIDATE is 1. Otherwise it leaves T2 valid.
- R6: A replayed response (`rsp_replay` with `rsp_tx`) overwrites the previous T3 with the new transmit time. When `enh_en` is 1 it also clears both previous-dialog validity flags.
- R7: `rpl_ready` is high for exactly the one cycle that follows each cycle in which `req_rx` is high.
- R8: `rpl_pend` rises together with `rpl_ready` and falls in the cycle after `rpl_ack` is sampled high. While it stays high and no new request arrives, `rpl_is_data`, `rpl_master` and `rpl_delay` do not change.
- R9: After reset, `rpl_ready` and `rpl_pend` are 0 and every stamp is invalid, so the first reply after reset is plain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_en | input | 1 | Enhanced invalidation rules enable |
| master_time | input | TS_W | Running master-time counter |
| req_rx | input | 1 | Request received strobe |
| req_dup | input | 1 | Received request is a duplicate; qualified by req_rx |
| rsp_tx | input | 1 | Response transmitted strobe |
| rsp_replay | input | 1 | Transmitted response is a replay; qualified by rsp_tx |
| rpl_ack | input | 1 | Packet builder has consumed the reply |
| rpl_ready | output | 1 | One-cycle pulse: new reply decision |
| rpl_pend | output | 1 | Reply decision held and not yet acknowledged |
| rpl_is_data | output | 1 | 1 = data reply, 0 = plain reply |
| rpl_master | output | TS_W | Master-time field (current T2) |
| rpl_delay | output | TS_W | Propagation-delay field (previous T3 - T2) |

## Verification
The checks assume the link layer never raises a request strobe and a response strobe in the same cycle. They also assume the replay flag appears only alongside a response strobe. The bench drives every stimulus as a single isolated strobe and keeps each qualifier paired with its strobe. The sweep covers completed and empty prior dialogs, with and without duplicates or replays, in both modes. It includes stamp pairs whose T3 has wrapped below T2. A second instance with the duplicate policy relaxed runs on the same stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic {
      RPL_PLAIN = 1'b0,
      RPL_DATA  = 1'b1
   } rpl_kind_e;
endpackage

// File: rtl/tmr_cur_stamp.sv
module tmr_cur_stamp #(
   parameter int TS_W           = 64,
   parameter bit DUP_INVALIDATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enh_en,
   input  logic [TS_W-1:0] master_time,
   input  logic            req_rx,
   input  logic            req_dup,
   input  logic            rsp_tx,
   input  logic            rsp_replay,
   output logic [TS_W-1:0] cur_t2,
   output logic            cur_t2_v,
   output logic            t2_v_next
);
   logic dup_kills;

   generate
      if (DUP_INVALIDATE) begin : g_dup_always
         assign dup_kills = req_dup;
      end else begin : g_dup_enh_only
         assign dup_kills = req_dup & enh_en;
      end
   endgenerate

   assign t2_v_next = ~dup_kills;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_t2   <= '0;
         cur_t2_v <= 1'b0;
      end else if (req_rx) begin
         cur_t2   <= master_time;
         cur_t2_v <= t2_v_next;
      end else if (rsp_tx && !rsp_replay) begin
         cur_t2_v <= 1'b0;
      end
   end

   // R4: input contract, a dialog closes only in a cycle without a new request
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_rx && rsp_tx));

   // R5: in enhanced mode a duplicate request leaves the current T2 invalid
   assert_dup_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rx && req_dup && enh_en) |=> !cur_t2_v);
endmodule

// File: rtl/tmr_prev_stamp.sv
module tmr_prev_stamp #(
   parameter int TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enh_en,
   input  logic [TS_W-1:0] master_time,
   input  logic            rsp_tx,
   input  logic            rsp_replay,
   input  logic [TS_W-1:0] cur_t2,
   input  logic            cur_t2_v,
   output logic            prv_t2_v,
   output logic            prv_t3_v,
   output logic [TS_W-1:0] prv_delay
);
   logic [TS_W-1:0] prv_t2;
   logic [TS_W-1:0] prv_t3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prv_t2   <= '0;
         prv_t3   <= '0;
         prv_t2_v <= 1'b0;
         prv_t3_v <= 1'b0;
      end else if (rsp_tx) begin
         prv_t3 <= master_time;
         if (rsp_replay) begin
            if (enh_en) begin
               prv_t2_v <= 1'b0;
               prv_t3_v <= 1'b0;
            end
         end else begin
            prv_t2   <= cur_t2;
            prv_t2_v <= cur_t2_v;
            prv_t3_v <= 1'b1;
         end
      end
   end

   assign prv_delay = prv_t3 - prv_t2;

   // R6: input contract, the replay flag only qualifies a response strobe
   assert_replay_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_replay |-> rsp_tx);

   // R4: a fresh (non-replayed) dialog close inherits the T2 validity of the current dialog
   assert_roll_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_tx && !rsp_replay) |=> (prv_t2_v == $past(cur_t2_v)));
endmodule

// File: rtl/tmr_reply_reg.sv
module tmr_reply_reg
   import tmr_pkg::*;
#(
   parameter int TS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_rx,
   input  logic            t2_v_next,
   input  logic            prv_t2_v,
   input  logic            prv_t3_v,
   input  logic [TS_W-1:0] master_time,
   input  logic [TS_W-1:0] prv_delay,
   input  logic            rpl_ack,
   output logic            rpl_ready,
   output logic            rpl_pend,
   output logic            rpl_is_data,
   output logic [TS_W-1:0] rpl_master,
   output logic [TS_W-1:0] rpl_delay
);
   rpl_kind_e kind_q;
   rpl_kind_e kind_d;

   assign kind_d = (t2_v_next && prv_t2_v && prv_t3_v) ? RPL_DATA : RPL_PLAIN;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rpl_ready  <= 1'b0;
         rpl_pend   <= 1'b0;
         kind_q     <= RPL_PLAIN;
         rpl_master <= '0;
         rpl_delay  <= '0;
      end else begin
         rpl_ready <= req_rx;
         if (req_rx) begin
            rpl_pend   <= 1'b1;
            kind_q     <= kind_d;
            rpl_master <= master_time;
            rpl_delay  <= prv_delay;
         end else if (rpl_ack) begin
            rpl_pend <= 1'b0;
         end
      end
   end

   assign rpl_is_data = (kind_q == RPL_DATA);

   // R8: a held reply does not move until it is consumed or superseded
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rpl_pend && !rpl_ack && !req_rx) |=>
         ($stable(rpl_is_data) && $stable(rpl_master) && $stable(rpl_delay) && rpl_pend));

   // R8: acknowledgement without a new request drops the pending flag
   assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rpl_ack && !req_rx) |=> !rpl_pend);
endmodule

// File: rtl/tm_reply_select.sv
module tm_reply_select #(
   parameter int TS_W           = 64,
   parameter bit DUP_INVALIDATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enh_en,
   input  logic [TS_W-1:0] master_time,
   input  logic            req_rx,
   input  logic            req_dup,
   input  logic            rsp_tx,
   input  logic            rsp_replay,
   input  logic            rpl_ack,
   output logic            rpl_ready,
   output logic            rpl_pend,
   output logic            rpl_is_data,
   output logic [TS_W-1:0] rpl_master,
   output logic [TS_W-1:0] rpl_delay
);
   generate
      if (TS_W < 2 || TS_W > 64) begin : g_bad_width
         $error("tm_reply_select: TS_W must lie in 2..64");
      end
   endgenerate

   logic [TS_W-1:0] cur_t2;
   logic            cur_t2_v;
   logic            t2_v_next;
   logic            prv_t2_v;
   logic            prv_t3_v;
   logic [TS_W-1:0] prv_delay;

   tmr_cur_stamp #(.TS_W(TS_W), .DUP_INVALIDATE(DUP_INVALIDATE)) u_cur (
      .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .master_time(master_time),
      .req_rx(req_rx), .req_dup(req_dup), .rsp_tx(rsp_tx), .rsp_replay(rsp_replay),
      .cur_t2(cur_t2), .cur_t2_v(cur_t2_v), .t2_v_next(t2_v_next)
   );

   tmr_prev_stamp #(.TS_W(TS_W)) u_prev (
      .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .master_time(master_time),
      .rsp_tx(rsp_tx), .rsp_replay(rsp_replay), .cur_t2(cur_t2), .cur_t2_v(cur_t2_v),
      .prv_t2_v(prv_t2_v), .prv_t3_v(prv_t3_v), .prv_delay(prv_delay)
   );

   tmr_reply_reg #(.TS_W(TS_W)) u_reply (
      .clk(clk), .rst_n(rst_n), .req_rx(req_rx), .t2_v_next(t2_v_next),
      .prv_t2_v(prv_t2_v), .prv_t3_v(prv_t3_v), .master_time(master_time),
      .prv_delay(prv_delay), .rpl_ack(rpl_ack), .rpl_ready(rpl_ready),
      .rpl_pend(rpl_pend), .rpl_is_data(rpl_is_data), .rpl_master(rpl_master),
      .rpl_delay(rpl_delay)
   );

   // R7: the decision pulse follows every request by one cycle and nothing else
   assert_ready_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_rx |=> rpl_ready);
   assert_ready_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rpl_ready |-> $past(req_rx));

   // R1: master field is the time sampled at the request strobe
   assert_master_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rpl_ready |-> (rpl_master == $past(master_time)));

   // R2: a data reply needs a complete previous dialog
   assert_data_needs_prev_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rpl_ready && rpl_is_data) |-> $past(prv_t2_v && prv_t3_v));

   // R5: enhanced duplicate request always yields a plain reply
   assert_enh_dup_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rx && req_dup && enh_en) |=> (rpl_ready && !rpl_is_data));
endmodule

// File: tb/sim_tm_reply_select.sv
`timescale 1ns/1ps
module sim_tm_reply_select;
   localparam int W = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         enh_en = 1'b0;
   logic [W-1:0] master_time = '0;
   logic         req_rx = 1'b0, req_dup = 1'b0, rsp_tx = 1'b0, rsp_replay = 1'b0, rpl_ack = 1'b0;

   logic         o0_ready, o0_pend, o0_data, o1_ready, o1_pend, o1_data;
   logic [W-1:0] o0_master, o0_delay, o1_master, o1_delay;

   tm_reply_select #(.TS_W(W), .DUP_INVALIDATE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .master_time(master_time),
      .req_rx(req_rx), .req_dup(req_dup), .rsp_tx(rsp_tx), .rsp_replay(rsp_replay),
      .rpl_ack(rpl_ack), .rpl_ready(o0_ready), .rpl_pend(o0_pend), .rpl_is_data(o0_data),
      .rpl_master(o0_master), .rpl_delay(o0_delay));

   tm_reply_select #(.TS_W(W), .DUP_INVALIDATE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .master_time(master_time),
      .req_rx(req_rx), .req_dup(req_dup), .rsp_tx(rsp_tx), .rsp_replay(rsp_replay),
      .rpl_ack(rpl_ack), .rpl_ready(o1_ready), .rpl_pend(o1_pend), .rpl_is_data(o1_data),
      .rpl_master(o1_master), .rpl_delay(o1_delay));

   int tests = 0;
   int fails = 0;

   // reference state per instance, built from the requirements
   logic [W-1:0] m_c2 [2];
   logic [W-1:0] m_p2 [2];
   logic [W-1:0] m_p3 [2];
   bit           m_cv [2];
   bit           m_pv2 [2];
   bit           m_pv3 [2];

   task automatic chk(input string tag, input int inst, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s u%0d: actual %0h expected %0h", tag, inst, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_c2[k] = '0; m_p2[k] = '0; m_p3[k] = '0;
         m_cv[k] = 1'b0; m_pv2[k] = 1'b0; m_pv3[k] = 1'b0;
      end
   endtask

   task automatic do_req(input bit dup, input logic [W-1:0] t, input string tag);
      bit           e_data [2];
      logic [W-1:0] e_dly [2];
      @(negedge clk);
      master_time = t; req_rx = 1'b1; req_dup = dup;
      for (int k = 0; k < 2; k++) begin
         bit nv;
         nv = !(dup && (enh_en || k == 0));
         e_data[k] = nv && m_pv2[k] && m_pv3[k];
         e_dly[k]  = m_p3[k] - m_p2[k];
         m_c2[k] = t; m_cv[k] = nv;
      end
      @(negedge clk);
      req_rx = 1'b0; req_dup = 1'b0;
      for (int k = 0; k < 2; k++) begin
         chk("R7 ready pulse", k, (k == 0) ? o0_ready : o1_ready, 1);
         chk({tag, " reply kind"}, k, (k == 0) ? o0_data : o1_data, e_data[k]);
         chk("R1 master field", k, (k == 0) ? o0_master : o1_master, t);
         chk("R3 delay field", k, (k == 0) ? o0_delay : o1_delay, e_dly[k]);
         chk("R8 pending set", k, (k == 0) ? o0_pend : o1_pend, 1);
      end
      @(negedge clk);
      chk("R7 pulse width", 0, o0_ready, 0);
      chk("R7 pulse width", 1, o1_ready, 0);
   endtask

   task automatic do_tx(input bit rep, input logic [W-1:0] t);
      @(negedge clk);
      master_time = t; rsp_tx = 1'b1; rsp_replay = rep;
      for (int k = 0; k < 2; k++) begin
         m_p3[k] = t;
         if (rep) begin
            if (enh_en) begin m_pv2[k] = 1'b0; m_pv3[k] = 1'b0; end
         end else begin
            m_p2[k] = m_c2[k]; m_pv2[k] = m_cv[k]; m_pv3[k] = 1'b1; m_cv[k] = 1'b0;
         end
      end
      @(negedge clk);
      rsp_tx = 1'b0; rsp_replay = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); rpl_ack = 1'b1;
      @(negedge clk); rpl_ack = 1'b0;
      chk("R8 ack clears", 0, o0_pend, 0);
      chk("R8 ack clears", 1, o1_pend, 0);
   endtask

   task automatic hold_chk();
      logic         d0 = o0_data;
      logic [W-1:0] ms0 = o0_master, dl0 = o0_delay;
      master_time = master_time + 16'd33;
      repeat (3) @(negedge clk);
      chk("R8 hold pend", 0, o0_pend, 1);
      chk("R8 hold kind", 0, o0_data, d0);
      chk("R8 hold master", 0, o0_master, ms0);
      chk("R8 hold delay", 0, o0_delay, dl0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      chk("R9 reset ready", 0, o0_ready, 0);
      chk("R9 reset pend", 0, o0_pend, 0);
      chk("R9 reset pend", 1, o1_pend, 0);
      rst_n = 1'b1;

      do_req(1'b0, 16'd100, "R9 first plain");
      do_tx(1'b0, 16'd130);
      do_req(1'b0, 16'd200, "R4 rollover");
      chk("R2 data after full dialog", 0, o0_data, 1);
      chk("R3 delay 30", 0, o0_delay, 30);
      hold_chk();
      do_ack();
      do_tx(1'b0, 16'd260);

      for (int p = 0; p < 32; p++) begin
         logic [W-1:0] base;
         enh_en = p[2];
         base = p[4] ? 16'hFFF0 : (16'h0400 + 16'(p * 64));
         if (p[0]) begin
            do_req(1'b0, base, "R2 prior req");
            do_tx(1'b0, base + 16'h0025);
         end
         if (p[3]) do_tx(1'b1, base + 16'h002C);
         do_req(1'b0, base + 16'd100, p[3] ? "R6 after replay" : "R2 sweep");
         if (p[1]) do_req(1'b1, base + 16'd120, "R5 duplicate");
         if (p[0] && !p[3] && !p[1])
            chk("R3 wrap delay", 0, o0_delay, 16'h0025);
         do_ack();
         do_tx(1'b0, base + 16'd150);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule